// File: doc/BRIEF.md
# Privilege-Checked Translation Cache

This block is a small fully associative cache of page translations for one processor. It holds virtual page numbers and their physical frames, together with a writable flag and a user-accessible flag for each entry. A lookup presents a virtual address, a read/write flag and the current privilege ring. One cycle later the block reports hit or miss, the translated physical address and a protection-fault flag.

The page-walk logic uses the fill port to install a leaf entry after a miss. Software can drop one page with the single-page invalidate port, which only ring 0 may use. A request from any other ring raises a trap and changes nothing. The level input `mode_i` gives the current virtualization mode (root or guest). Every change of that level empties the whole cache, and a miss never empties it.

Top module: `priv_tlb`

## Requirements
- R1: After reset every entry is invalid, all registered outputs are 0 and every lookup misses.
- R2: A lookup in cycle t is answered in cycle t+1 with lk_done_o=1. On a hit, lk_paddr_o = {frame, vaddr[11:0]}, where the frame is fill PTE bits 47:12.
- R3: Fill PTE encoding: bit 0 is present, bit 1 is writable, bit 2 is user-accessible and bits 47:12 hold the frame. A fill with bit 0 clear installs nothing and does not advance the victim pointer.
- R4: Rings 0, 1 and 2 (ring code 0..2) are supervisor and may read an entry whose user bit is clear without a fault. A ring-3 access to such an entry faults.
- R5: A write to an entry whose writable bit is clear faults in any ring. lk_fault_o is only set with lk_hit_o. A miss gives hit=0, fault=0 and paddr=0.
- R6: The cache has 8 entries. Fills that allocate take slots 0,1,...,7 in turn and then wrap, so the ninth new page evicts the first one installed.
- R7: A fill for a page that is already cached overwrites that entry in place and does not use up a victim slot.
- R8: An invalidate from ring 0 removes only the entry that matches the given page.
- R9: An invalidate from ring 1, 2 or 3 sets inv_trap_o in the next cycle and leaves every entry unchanged.
- R10: Any change of mode_i clears every entry.
- R11: A lookup miss never removes entries.
- R12: If a fill and a mode change occur in the same cycle, the fill is dropped and the cache ends up empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Virtualization mode level; any change flushes |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 48 | Lookup virtual address |
| lk_write_i | input | 1 | Lookup is a write |
| lk_ring_i | input | 2 | Current privilege ring |
| lk_done_o | output | 1 | Registered: result valid |
| lk_hit_o | output | 1 | Registered: translation found |
| lk_paddr_o | output | 48 | Registered: physical address |
| lk_fault_o | output | 1 | Registered: protection fault |
| fill_valid_i | input | 1 | Install request |
| fill_vaddr_i | input | 48 | Virtual address of the installed page |
| fill_pte_i | input | 48 | Leaf entry: frame and permission bits |
| inv_valid_i | input | 1 | Single-page invalidate request |
| inv_vaddr_i | input | 48 | Page to invalidate |
| inv_ring_i | input | 2 | Ring issuing the invalidate |
| inv_trap_o | output | 1 | Registered: invalidate refused, privilege trap |

## Verification
The assertions check these rules on every cycle:
- At most one entry matches a lookup.
- A mode change empties the array.
- A refused invalidate or a plain miss leaves the valid set as it was.
- A fault never comes without a hit, and a ring-3 access to a supervisor-only page faults.
- The page offset passes through unchanged.
- The victim pointer holds still when nothing is allocated.

Only the bench scenarios can show the rest:
- The complete permission matrix over every ring and access type.
- The exact order of round-robin eviction.
- In-place refill.
- The priority of a flush over a fill in the same cycle.

// File: rtl/priv_tlb_pkg.sv
package priv_tlb_pkg;
  typedef enum logic [1:0] {RING0 = 2'd0, RING1 = 2'd1, RING2 = 2'd2, RING3 = 2'd3} ring_e;

  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_WRITE   = 1;
  localparam int unsigned PTE_USER    = 2;

  typedef struct packed {
    logic wr;
    logic usr;
  } perm_t;
endpackage

// File: rtl/priv_tlb_rr.sv
module priv_tlb_rr #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ptr_q <= '0;
    else if (adv_i) begin
      if (ptr_q == IDX_W'(N - 1))    ptr_q <= '0;
      else                           ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  p_rr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
  p_rr_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= IDX_W'(N - 1));
endmodule

// File: rtl/priv_tlb_perm.sv
module priv_tlb_perm
  import priv_tlb_pkg::*;
(
  input  logic  hit_i,
  input  logic  write_i,
  input  ring_e ring_i,
  input  perm_t perm_i,
  output logic  fault_o
);
  logic user_viol;
  logic write_viol;

  // one user/supervisor bit: rings 0..2 all count as supervisor
  assign user_viol  = (ring_i == RING3) && !perm_i.usr;
  assign write_viol = write_i && !perm_i.wr;
  assign fault_o    = hit_i && (user_viol || write_viol);
endmodule

// File: rtl/priv_tlb_array.sv
module priv_tlb_array
  import priv_tlb_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 36,
  parameter int unsigned PFN_W = 36,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PFN_W-1:0] lk_pfn_o,
  output perm_t            lk_perm_o,
  input  logic             inv_en_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  perm_t            fill_perm_i,
  input  logic [IDX_W-1:0] victim_i,
  output logic             fill_alloc_o,
  output logic [N-1:0]     valid_o
);
  logic [N-1:0]     valid_q;
  logic [VPN_W-1:0] vpn_q  [N];
  logic [PFN_W-1:0] pfn_q  [N];
  perm_t            perm_q [N];

  logic [N-1:0] lk_match, inv_match, fill_match, wr_sel;
  logic         fill_hit;

  assign fill_hit     = |fill_match;
  assign fill_alloc_o = fill_en_i && !fill_hit && !flush_i;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign lk_match[i]   = valid_q[i] && (vpn_q[i] == lk_vpn_i);
    assign inv_match[i]  = valid_q[i] && (vpn_q[i] == inv_vpn_i);
    assign fill_match[i] = valid_q[i] && (vpn_q[i] == fill_vpn_i);
    // refill of a cached page lands in place, otherwise in the victim slot
    assign wr_sel[i] = fill_en_i && (fill_hit ? fill_match[i] : (victim_i == IDX_W'(i)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          valid_q[i] <= 1'b0;
      else if (flush_i)                     valid_q[i] <= 1'b0;
      else if (wr_sel[i])                   valid_q[i] <= 1'b1;
      else if (inv_en_i && inv_match[i])    valid_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end else if (!flush_i && wr_sel[i]) begin
        vpn_q[i]  <= fill_vpn_i;
        pfn_q[i]  <= fill_pfn_i;
        perm_q[i] <= fill_perm_i;
      end
    end
  end

  always_comb begin
    lk_pfn_o  = '0;
    lk_perm_o = '0;
    for (int k = 0; k < N; k++) begin
      if (lk_match[k]) begin
        lk_pfn_o  = lk_pfn_o | pfn_q[k];
        lk_perm_o = lk_perm_o | perm_q[k];
      end
    end
  end

  assign lk_hit_o = |lk_match;
  assign valid_o  = valid_q;

  p_match_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
  p_flush_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  p_fill_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !flush_i) |=> (valid_q != '0));
endmodule

// File: rtl/priv_tlb.sv
module priv_tlb
  import priv_tlb_pkg::*;
#(
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 48,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned VPN_W  = VA_W - PAGE_W,
  localparam int unsigned PFN_W  = PA_W - PAGE_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic            lk_valid_i,
  input  logic [VA_W-1:0] lk_vaddr_i,
  input  logic            lk_write_i,
  input  logic [1:0]      lk_ring_i,
  output logic            lk_done_o,
  output logic            lk_hit_o,
  output logic [PA_W-1:0] lk_paddr_o,
  output logic            lk_fault_o,
  input  logic            fill_valid_i,
  input  logic [VA_W-1:0] fill_vaddr_i,
  input  logic [PA_W-1:0] fill_pte_i,
  input  logic            inv_valid_i,
  input  logic [VA_W-1:0] inv_vaddr_i,
  input  logic [1:0]      inv_ring_i,
  output logic            inv_trap_o
);
  logic             mode_q;
  logic             flush;
  logic             fill_en, inv_en, fill_alloc;
  logic             hit_c, fault_c;
  logic [PFN_W-1:0] pfn_c;
  perm_t            perm_c, fill_perm;
  logic [IDX_W-1:0] victim;
  logic [ENTRIES-1:0] valid;
  ring_e            lk_ring, inv_ring;

  assign lk_ring  = ring_e'(lk_ring_i);
  assign inv_ring = ring_e'(inv_ring_i);

  // any root/guest transition empties the array; misses never do
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end
  assign flush = (mode_i != mode_q);

  assign fill_en   = fill_valid_i && fill_pte_i[PTE_PRESENT];
  assign fill_perm = '{wr: fill_pte_i[PTE_WRITE], usr: fill_pte_i[PTE_USER]};
  assign inv_en    = inv_valid_i && (inv_ring == RING0);

  priv_tlb_rr #(.N(ENTRIES)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (fill_alloc),
    .ptr_o (victim)
  );

  priv_tlb_array #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .lk_vpn_i    (lk_vaddr_i[VA_W-1:PAGE_W]),
    .lk_hit_o    (hit_c),
    .lk_pfn_o    (pfn_c),
    .lk_perm_o   (perm_c),
    .inv_en_i    (inv_en),
    .inv_vpn_i   (inv_vaddr_i[VA_W-1:PAGE_W]),
    .fill_en_i   (fill_en),
    .fill_vpn_i  (fill_vaddr_i[VA_W-1:PAGE_W]),
    .fill_pfn_i  (fill_pte_i[PA_W-1:PAGE_W]),
    .fill_perm_i (fill_perm),
    .victim_i    (victim),
    .fill_alloc_o(fill_alloc),
    .valid_o     (valid)
  );

  priv_tlb_perm u_perm (
    .hit_i  (hit_c),
    .write_i(lk_write_i),
    .ring_i (lk_ring),
    .perm_i (perm_c),
    .fault_o(fault_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o  <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_paddr_o <= '0;
      lk_fault_o <= 1'b0;
      inv_trap_o <= 1'b0;
    end else begin
      lk_done_o  <= lk_valid_i;
      lk_hit_o   <= lk_valid_i && hit_c;
      lk_paddr_o <= (lk_valid_i && hit_c) ? {pfn_c, lk_vaddr_i[PAGE_W-1:0]} : '0;
      lk_fault_o <= lk_valid_i && fault_c;
      inv_trap_o <= inv_valid_i && (inv_ring != RING0);
    end
  end

  p_fault_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o);
  p_miss_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_hit_o) |-> (lk_paddr_o == '0));
  p_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && hit_c) |=> (lk_paddr_o[PAGE_W-1:0] == $past(lk_vaddr_i[PAGE_W-1:0])));
  p_user_ring_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && hit_c && lk_ring == RING3 && !perm_c.usr) |=> lk_fault_o);
  p_trap_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_ring != RING0 && !fill_en && !flush) |=> $stable(valid));
  p_miss_no_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !hit_c && !flush && !fill_en && !inv_valid_i) |=> $stable(valid));
endmodule

// File: tb/priv_tlb_tb_top.sv
module priv_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic [1:0]  lk_ring = '0;
  logic        lk_done, lk_hit, lk_fault;
  logic [47:0] lk_paddr;
  logic        fill_valid = 1'b0;
  logic [47:0] fill_vaddr = '0, fill_pte = '0;
  logic        inv_valid = 1'b0;
  logic [47:0] inv_vaddr = '0;
  logic [1:0]  inv_ring = '0;
  logic        inv_trap;

  int total = 0;
  int bad = 0;

  // bench model
  bit [35:0] m_vpn [N];
  bit [35:0] m_pfn [N];
  bit        m_w [N];
  bit        m_u [N];
  bit        m_v [N];
  int        m_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_tlb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_write_i(lk_write), .lk_ring_i(lk_ring),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_paddr_o(lk_paddr), .lk_fault_o(lk_fault),
    .fill_valid_i(fill_valid), .fill_vaddr_i(fill_vaddr), .fill_pte_i(fill_pte),
    .inv_valid_i(inv_valid), .inv_vaddr_i(inv_vaddr), .inv_ring_i(inv_ring),
    .inv_trap_o(inv_trap)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_pte(bit [35:0] pfn, bit w, bit u, bit p);
    return {pfn, 9'd0, u, w, p};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  task automatic do_fill(bit [35:0] vpn, bit [35:0] pfn, bit w, bit u, bit p);
    int slot;
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = {vpn, 12'h000}; fill_pte = mk_pte(pfn, w, u, p);
    @(negedge clk);
    fill_valid = 1'b0;
    if (p) begin
      slot = -1;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) slot = i;
      if (slot < 0) begin
        slot = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_v[slot] = 1'b1; m_vpn[slot] = vpn; m_pfn[slot] = pfn; m_w[slot] = w; m_u[slot] = u;
    end
  endtask

  task automatic do_lookup(bit [35:0] vpn, bit [11:0] off, bit wr, bit [1:0] ring, string req);
    bit        e_hit = 1'b0, e_fault = 1'b0;
    bit [47:0] e_pa = '0;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_vpn[i] == vpn) begin
        e_hit = 1'b1;
        e_pa = {m_pfn[i], off};
        e_fault = (ring == 2'd3 && !m_u[i]) || (wr && !m_w[i]);
      end
    end
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_write = wr; lk_ring = ring;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " done"},  64'(lk_done),  64'(1'b1));
    check({req, " hit"},   64'(lk_hit),   64'(e_hit));
    check({req, " paddr"}, 64'(lk_paddr), 64'(e_pa));
    check({req, " fault"}, 64'(lk_fault), 64'(e_fault));
  endtask

  task automatic do_inv(bit [35:0] vpn, bit [1:0] ring, string req);
    @(negedge clk);
    inv_valid = 1'b1; inv_vaddr = {vpn, 12'h0}; inv_ring = ring;
    @(negedge clk);
    inv_valid = 1'b0;
    check({req, " trap"}, 64'(inv_trap), 64'(ring != 2'd0));
    if (ring == 2'd0)
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) m_v[i] = 1'b0;
  endtask

  task automatic toggle_mode();
    @(negedge clk);
    mode = ~mode;
    model_clear();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 done",  64'(lk_done),  0);
    check("R1 hit",   64'(lk_hit),   0);
    check("R1 fault", 64'(lk_fault), 0);
    check("R1 paddr", 64'(lk_paddr), 0);
    check("R1 trap",  64'(inv_trap), 0);
    do_lookup(36'h0, 12'h0, 1'b0, 2'd0, "R1 empty");

    // R2 R4 R5 R6: fill all 8 slots, sweep ring x access over every permission pair
    for (int i = 0; i < N; i++)
      do_fill(36'h100 + 36'(i), 36'h5000 + 36'(i * 3), bit'(i % 2), bit'((i / 2) % 2), 1'b1);
    for (int i = 0; i < N; i++)
      for (int r = 0; r < 4; r++)
        for (int w = 0; w < 2; w++)
          do_lookup(36'h100 + 36'(i), 12'((i * 37 + r * 5 + w * 911) & 12'hfff), bit'(w), 2'(r),
                    "R2_R4_R5 sweep");

    // R3: non-present fill ignored, pointer not advanced
    do_fill(36'h777, 36'h9999, 1'b1, 1'b1, 1'b0);
    do_lookup(36'h777, 12'h123, 1'b0, 2'd0, "R3 not present");
    // R6: ninth new page evicts slot 0
    do_fill(36'h200, 36'h6000, 1'b1, 1'b1, 1'b1);
    do_lookup(36'h100, 12'h010, 1'b0, 2'd0, "R6 evicted");
    do_lookup(36'h101, 12'h011, 1'b0, 2'd0, "R6 kept");
    do_lookup(36'h200, 12'hfff, 1'b1, 2'd3, "R6 new");

    // R7: refill in place, no slot consumed
    do_fill(36'h101, 36'h7abc, 1'b1, 1'b1, 1'b1);
    do_lookup(36'h101, 12'h044, 1'b1, 2'd3, "R7 refill");
    do_fill(36'h201, 36'h6001, 1'b0, 1'b0, 1'b1);
    do_lookup(36'h102, 12'h055, 1'b0, 2'd1, "R7 neighbour kept");
    do_lookup(36'h101, 12'h066, 1'b0, 2'd0, "R7 victim slot1");

    // R9: invalidate from rings 1..3 refused
    for (int r = 1; r < 4; r++) begin
      do_inv(36'h102, 2'(r), "R9 refused");
      do_lookup(36'h102, 12'h077, 1'b0, 2'd0, "R9 still cached");
    end
    // R8: ring-0 invalidate removes only the match
    do_inv(36'h102, 2'd0, "R8 allowed");
    do_lookup(36'h102, 12'h088, 1'b0, 2'd0, "R8 removed");
    do_lookup(36'h103, 12'h099, 1'b0, 2'd0, "R8 other kept");

    // R11: misses do not flush
    for (int k = 0; k < 4; k++) do_lookup(36'h900 + 36'(k), 12'h1, 1'b0, 2'd3, "R11 miss");
    for (int i = 3; i < N; i++) do_lookup(36'h100 + 36'(i), 12'h2, 1'b0, 2'd0, "R11 survives");

    // R10: each mode change empties everything
    toggle_mode();
    @(negedge clk);
    for (int i = 3; i < N; i++) do_lookup(36'h100 + 36'(i), 12'h3, 1'b0, 2'd0, "R10 flushed");
    do_fill(36'h300, 36'h1234, 1'b1, 1'b1, 1'b1);
    do_lookup(36'h300, 12'h4, 1'b0, 2'd0, "R10 refill after");
    toggle_mode();
    @(negedge clk);
    do_lookup(36'h300, 12'h4, 1'b0, 2'd0, "R10 flush back");

    // R12: fill and mode change in the same cycle, flush wins
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = {36'h400, 12'h0}; fill_pte = mk_pte(36'h4444, 1'b1, 1'b1, 1'b1);
    mode = ~mode;
    @(negedge clk);
    fill_valid = 1'b0;
    model_clear();
    do_lookup(36'h400, 12'h5, 1'b0, 2'd0, "R12 fill dropped");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule